// File: doc/BRIEF.md
# Burst Address Counter with Rewind

This block is the address front end of one memory port. It holds the word address presented to the memory array and moves that address on each rising clock edge. Three active-low commands, sampled on the port clock, control it. A strobe loads a fresh external address. A step command advances the address by one for burst transfers. A rewind command jumps back to the start of the current burst. When no command is asserted, the address is held.

Each strobe load also copies the loaded address into a separate base register, which is the burst start. Rewind restores the counter from that register, so a burst can be replayed from its first word without driving the external address again. Steps never touch the base.

Internally a priority decoder turns the three commands into one of four operations: OP_REWIND, OP_LOAD, OP_STEP and OP_HOLD. The counter register and the base register each act on that operation in a single unique case. The transitions are these:
- Any operation moves to itself or to any other on the next edge, as the commands dictate.
- OP_LOAD sets counter = base = external address.
- OP_STEP sets counter = counter + 1.
- OP_REWIND sets counter = base.
- OP_HOLD keeps both registers.

Top module: `burst_addr_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both the counter and the base register to zero. A rewind issued right after reset therefore yields address 0.
- R2: With strobe_n low and rewind_n high at a rising edge, addr_out equals addr_in after that edge.
- R3: With step_n low and both rewind_n and strobe_n high, addr_out increases by exactly one at each rising edge.
- R4: Stepping from the all-ones address gives zero, with natural rollover and no other wrap boundary.
- R5: With rewind_n low at a rising edge, addr_out after that edge equals the address of the most recent strobe load.
- R6: The base register is written only by a strobe load that takes effect. Steps, holds and rewinds leave it unchanged, including a strobe that is masked by a simultaneous rewind.
- R7: Priority is fixed: rewind over strobe, and strobe over step.
- R8: With rewind_n, strobe_n and step_n all high, addr_out does not change.
- R9: The address width is the parameter ADDR_W, with a default of 16. The counter and base are both ADDR_W bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Load addr_in into the counter and the base, active low |
| step_n | input | 1 | Advance the counter by one, active low |
| rewind_n | input | 1 | Restore the counter from the base, active low |
| addr_in | input | ADDR_W | External address taken by a strobe |
| addr_out | output | ADDR_W | Current internal address to the memory array |

## Verification
The bench targets several corner cases. Rollover from 0xFFFF: a design that saturates or stalls there would hold 0xFFFF instead of returning to 0. Rewind asserted together with a strobe: a wrong priority would load the new address, and a careless base write would move the burst start even though the counter ignored the strobe. Rewinding after several steps and again after a later rewind shows whether increments corrupt the stored base. Rewind straight after reset shows whether reset cleared the base as well as the counter.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_STEP   = 2'd1,
        OP_LOAD   = 2'd2,
        OP_REWIND = 2'd3
    } burst_op_e;
endpackage

// File: rtl/burst_op_sel.sv
module burst_op_sel
    import burst_pkg::*;
(
    input  logic      strobe_n,
    input  logic      step_n,
    input  logic      rewind_n,
    output burst_op_e op
);
    // Fixed priority: rewind, then load, then step.
    always_comb begin
        if (!rewind_n)      op = OP_REWIND;
        else if (!strobe_n) op = OP_LOAD;
        else if (!step_n)   op = OP_STEP;
        else                op = OP_HOLD;
    end

    always_comb begin
        AST_REWIND_WINS: assert (rewind_n || op == OP_REWIND); // R7
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_op_e         op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] base_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
        end else begin
            unique case (op)
                OP_LOAD:   base_addr <= load_addr;
                OP_STEP,
                OP_REWIND,
                OP_HOLD:   base_addr <= base_addr;
                default:   base_addr <= base_addr;
            endcase
        end
    end

    AST_BASE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LOAD) |=> $stable(base_addr)); // R6
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_op_e         op,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] count
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_REWIND: count <= base_addr;
                OP_LOAD:   count <= load_addr;
                OP_STEP:   count <= count + ONE;
                OP_HOLD:   count <= count;
                default:   count <= count;
            endcase
        end
    end

    AST_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && count == '1) |=> (count == '0)); // R4
endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              rewind_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    burst_op_e         op;
    logic [ADDR_W-1:0] base_addr;

    burst_op_sel u_sel (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .rewind_n (rewind_n),
        .op       (op)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_addr (addr_in),
        .base_addr (base_addr)
    );

    burst_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_addr (addr_in),
        .base_addr (base_addr),
        .count     (addr_out)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && base_addr == '0)); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (rewind_n && !strobe_n) |=> (addr_out == $past(addr_in))); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (rewind_n && strobe_n && !step_n) |=> (addr_out == $past(addr_out) + ADDR_W'(1))); // R3
    AST_REWIND_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (!rewind_n) |=> (addr_out == $past(base_addr))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rewind_n && strobe_n && step_n) |=> $stable(addr_out)); // R8
endmodule

// File: tb/sim_burst_addr_unit.sv
`timescale 1ns/1ps
module sim_burst_addr_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strobe_n = 1'b1;
    logic         step_n = 1'b1;
    logic         rewind_n = 1'b1;
    logic [W-1:0] addr_in = '0;
    logic [W-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] m_cnt;
    logic [W-1:0] m_base;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_unit #(.ADDR_W(W)) u0 (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .step_n(step_n),
        .rewind_n(rewind_n), .addr_in(addr_in), .addr_out(addr_out)
    );

    // Driver: at a falling edge, apply one command, predict, queue the prediction.
    task automatic cyc(input logic rw, input logic st, input logic sp,
                       input logic [W-1:0] a, input string tag);
        rewind_n = rw; strobe_n = st; step_n = sp; addr_in = a;
        if (!rw)      m_cnt = m_base;
        else if (!st) begin m_cnt = a; m_base = a; end
        else if (!sp) m_cnt = m_cnt + W'(1);
        @(posedge clk);
        #1;
        exp_q.push_back(m_cnt);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare at the falling edge after each command.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_out !== e) begin
                errors++;
                $display("FAIL %s: addr_out=%h expected=%h", t, addr_out, e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_cnt = '0; m_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (addr_out !== '0) begin
            errors++;
            $display("FAIL R1: addr_out=%h expected=%h", addr_out, 16'h0);
        end
        cyc(0, 1, 1, 16'hAAAA, "R1 rewind after reset");
        cyc(1, 0, 1, 16'h1234, "R2 load");
        cyc(1, 1, 0, 16'h0000, "R3 step");
        cyc(1, 1, 0, 16'h0000, "R3 step");
        cyc(1, 1, 0, 16'h0000, "R3 step");
        cyc(1, 1, 1, 16'h9999, "R8 hold");
        cyc(1, 1, 1, 16'h0000, "R8 hold");
        cyc(0, 1, 1, 16'h0000, "R5 rewind");
        cyc(0, 1, 0, 16'h0000, "R7 rewind over step");
        cyc(1, 0, 0, 16'hFFFE, "R7 load over step");
        cyc(1, 1, 0, 16'h0000, "R3 step to ffff");
        cyc(1, 1, 0, 16'h0000, "R4 rollover");
        cyc(1, 1, 0, 16'h0000, "R4 step after rollover");
        cyc(0, 0, 1, 16'h5555, "R7 rewind over strobe");
        cyc(1, 1, 0, 16'h0000, "R3 step");
        cyc(0, 1, 1, 16'h0000, "R6 base kept after masked strobe");
        cyc(0, 0, 0, 16'h7777, "R7 all asserted");
        cyc(1, 0, 1, 16'h0042, "R2 reload");
        cyc(1, 1, 0, 16'h0000, "R3 step");
        cyc(0, 1, 1, 16'h0000, "R6 base follows new load");
        cyc(1, 1, 1, 16'h0000, "R9 width hold");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule